// File: doc/BRIEF.md
# Dual-Rate SPI Master

This block is an SPI master driven through a four-word register port. A transfer has two phases: a write phase and a read phase. Each phase has its own bit count and its own clock divider. The read phase follows the last write bit with no idle cycles between them. One data register serves both directions. Every bit period shifts one bit out of that register and shifts the bit sampled from the line back in. As a result, the received bits end up at the end of the register that matches the selected bit order.

Software loads a configuration word and a data word, then writes a transfer descriptor. The descriptor does not act at once. It waits as pending until the engine reaches a transfer boundary.

When the engine is idle, a pending descriptor starts a transfer on the next clock. When the engine is busy, a pending descriptor is taken at the end of the last bit. The following transfer then starts with chip select still asserted.

A half-duplex option turns the single data pin around for the read phase. An offline option releases all pins.

Top module: `spi_split_master`

## Requirements
- R1: After reset, cs_n_o is all ones and sclk_o is 0. The configuration word (address 0), the descriptor word (address 1) and the status word (address 3) all read back 0. Both dividers therefore start at 2.
- R2: Register map, selected by reg_addr:
  - Address 0 is configuration. Bits 5:0 are the flags: bit0 offline, bit1 spare, bit2 clock polarity, bit3 clock phase, bit4 LSB-first, bit5 half-duplex. Bits 23:16 hold the write divider minus 2, and bits 31:24 hold the read divider minus 2.
  - Address 1 is the descriptor. Bits 15:0 hold the chip-select mask, bits 23:16 the write bit count and bits 31:24 the read bit count.
  - Address 2 is the data register.
  - Address 3 is status: bit0 is descriptor pending and bit1 is busy.
  - While a transfer runs, cs_n_o equals the inverse of the low CS_W bits of the mask.
- R3: Each write bit lasts exactly the write divider in clocks, and each read bit lasts exactly the read divider. Chip select is therefore asserted for exactly W·Dw + R·Dr clocks, with no gap between the phases.
- R4: Each bit has a setup half of ceil(D/2) clocks, during which sclk_o sits at polarity XOR phase, and a hold half of floor(D/2) clocks at the opposite level. sclk_o rests at the polarity level whenever no transfer runs. Each bit therefore makes exactly two sclk_o transitions.
- R5: MSB-first mode drives the register MSB and enters received bits at the LSB. LSB-first mode drives the LSB and enters received bits at the MSB. mosi_o is constant for the whole bit, and the line is sampled at the end of the setup half.
- R6: In 4-wire mode (bit5 clear), every bit of both phases is sampled from miso_i. mosi_o and mosi_oe keep driving during the read phase.
- R7: In half-duplex mode (bit5 set), every bit is sampled from mosi_i. mosi_oe is low exactly during the read-phase clocks.
- R8: A descriptor written during a transfer takes effect at that transfer's final bit boundary. Chip select stays asserted continuously into the chained transfer, which uses the new mask, lengths and data continuation.
- R9: A descriptor with both bit counts 0 is consumed within two clocks. It produces no sclk_o transition and no chip-select assertion.
- R10: A data-register write while busy is ignored.
- R11: With the offline flag set, pads_en and mosi_oe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | CS_W | Active-low chip selects |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for the data-out pin |
| mosi_i | input | 1 | Data pin read-back, used as input in half-duplex |
| miso_i | input | 1 | Serial data in (4-wire) |
| pads_en | output | 1 | Output enable for sclk and chip selects |

## Verification
The sweep covers every polarity, phase, bit-order and duplex combination, paired with odd and even dividers that differ between the two phases. It also uses splits where one phase is empty.

- An engine that rounded odd dividers the wrong way would show up in the count of setup-level clocks.
- An engine that used one divider for both phases would get the chip-select time wrong.
- Sampling the wrong pin would corrupt the returned word against an arithmetic model of the rotation.

A chained pair of descriptors checks for a single continuous chip-select run and for the second mask. A data write inside that transfer must not disturb the result. An all-zero descriptor must leave the pins completely still.

// File: rtl/spi_split_master.sv
module spi_split_master #(
  parameter int CS_W   = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sclk_o,
  output logic [CS_W-1:0]   cs_n_o,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              mosi_i,
  input  logic              miso_i,
  output logic              pads_en
);
  localparam int LEN_W = 8;
  localparam int DIV_W = LEN_W + 1;

  logic [5:0]        flags;
  logic [LEN_W-1:0]  wdiv_f, rdiv_f;
  logic              pend;
  logic [15:0]       p_cs;
  logic [LEN_W-1:0]  p_w, p_r;
  logic              active, hold, rx_q;
  logic [DIV_W-1:0]  cnt;
  logic [LEN_W-1:0]  wleft, rleft;
  logic [CS_W-1:0]   csm;
  logic [DATA_W-1:0] dreg;

  wire offline = flags[0];
  wire cpol    = flags[2];
  wire cpha    = flags[3];
  wire lsb     = flags[4];
  wire hd      = flags[5];
  wire lead    = cpol ^ cpha;

  wire [DIV_W-1:0] wdiv = DIV_W'(wdiv_f) + DIV_W'(2);
  wire [DIV_W-1:0] rdiv = DIV_W'(rdiv_f) + DIV_W'(2);

  wire in_write = (wleft != '0);
  wire [DIV_W-1:0] cur_div = in_write ? wdiv : rdiv;
  wire [DIV_W-1:0] nxt_div = (wleft > LEN_W'(1)) ? wdiv : rdiv;
  wire [DIV_W-1:0] new_div = (p_w != '0) ? wdiv : rdiv;
  wire last_bit = ({1'b0, wleft} + {1'b0, rleft}) == DIV_W'(1);
  wire bit_end  = active && hold && (cnt == '0);
  wire boundary = !active || (bit_end && last_bit);
  wire p_zero   = (p_w == '0) && (p_r == '0);
  wire take     = pend && !p_zero && boundary;
  wire in_bit   = hd ? mosi_i : miso_i;

  function automatic logic [DIV_W-1:0] setup_m1(input logic [DIV_W-1:0] d);
    return d - (d >> 1) - DIV_W'(1);
  endfunction

  function automatic logic [DIV_W-1:0] hold_m1(input logic [DIV_W-1:0] d);
    return (d >> 1) - DIV_W'(1);
  endfunction

  assign sclk_o  = active ? (hold ? ~lead : lead) : cpol;
  assign cs_n_o  = active ? ~csm : '1;
  assign mosi_o  = lsb ? dreg[0] : dreg[DATA_W-1];
  assign mosi_oe = !offline && !(hd && active && !in_write);
  assign pads_en = !offline;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {rdiv_f, wdiv_f, 10'b0, flags};
      2'd1:    reg_rdata = {p_r, p_w, p_cs};
      2'd2:    reg_rdata = 32'(dreg);
      default: reg_rdata = {30'b0, active, pend};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= '0;
      wdiv_f <= '0;
      rdiv_f <= '0;
      pend   <= 1'b0;
      p_cs   <= '0;
      p_w    <= '0;
      p_r    <= '0;
      active <= 1'b0;
      hold   <= 1'b0;
      rx_q   <= 1'b0;
      cnt    <= '0;
      wleft  <= '0;
      rleft  <= '0;
      csm    <= '0;
      dreg   <= '0;
    end else begin
      if (active) begin
        if (cnt != '0) begin
          cnt <= cnt - DIV_W'(1);
        end else if (!hold) begin
          rx_q <= in_bit;
          hold <= 1'b1;
          cnt  <= hold_m1(cur_div);
        end else begin
          dreg <= lsb ? {rx_q, dreg[DATA_W-1:1]} : {dreg[DATA_W-2:0], rx_q};
          if (in_write) wleft <= wleft - LEN_W'(1);
          else          rleft <= rleft - LEN_W'(1);
          hold <= 1'b0;
          cnt  <= setup_m1(nxt_div);
          if (last_bit) active <= 1'b0;
        end
      end
      if (boundary && pend) pend <= 1'b0;
      if (take) begin
        csm    <= p_cs[CS_W-1:0];
        wleft  <= p_w;
        rleft  <= p_r;
        cnt    <= setup_m1(new_div);
        hold   <= 1'b0;
        active <= 1'b1;
      end
      if (reg_we) begin
        case (reg_addr)
          2'd0: begin
            flags  <= reg_wdata[5:0];
            wdiv_f <= reg_wdata[23:16];
            rdiv_f <= reg_wdata[31:24];
          end
          2'd1: begin
            pend <= 1'b1;
            p_cs <= reg_wdata[15:0];
            p_w  <= reg_wdata[23:16];
            p_r  <= reg_wdata[31:24];
          end
          2'd2: if (!active) dreg <= reg_wdata[DATA_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_split_master_chk.sv
module spi_split_master_chk #(
  parameter int CS_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [1:0]      reg_addr,
  input logic            sclk_o,
  input logic [CS_W-1:0] cs_n_o,
  input logic            mosi_o,
  input logic            active,
  input logic            hold,
  input logic [8:0]      cnt,
  input logic            last_bit,
  input logic            pend,
  input logic [7:0]      p_w,
  input logic [7:0]      p_r,
  input logic            cpol
);
  p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (sclk_o == cpol) && (cs_n_o == '1));

  p_half_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt != '0 && !(reg_we && reg_addr == 2'd0)) |=> $stable(sclk_o));

  p_mosi_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !(hold && cnt == '0) && !(reg_we && reg_addr == 2'd0)) |=> $stable(mosi_o));

  p_cs_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !(hold && cnt == '0 && last_bit)) |=> active && $stable(cs_n_o));

  p_pend_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && pend && !(reg_we && reg_addr == 2'd1)) |=> !pend);

  p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && pend && p_w == '0 && p_r == '0) |=> !active);
endmodule

bind spi_split_master spi_split_master_chk #(.CS_W(CS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o), .active(active),
  .hold(hold), .cnt(cnt), .last_bit(last_bit), .pend(pend),
  .p_w(p_w), .p_r(p_r), .cpol(flags[2])
);

// File: tb/spi_split_master_bench.sv
module spi_split_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CS_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sclk_o, mosi_o, mosi_oe, mosi_i, miso_i, pads_en;
  logic [CS_W-1:0] cs_n_o;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  int cs_cyc, lead_cyc, tog, runs, idle_bad, oe_low;
  logic prev_sclk, prev_as;
  logic [CS_W-1:0] cs_seen;
  bit cur_lead, cur_cpol;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign miso_i = ~mosi_o;
  assign mosi_i = mosi_oe ? mosi_o : 1'b1;

  spi_split_master #(.CS_W(CS_W), .DATA_W(32)) u_spi_split_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_o(sclk_o),
    .cs_n_o(cs_n_o), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .miso_i(miso_i), .pads_en(pads_en)
  );

  always @(negedge clk) begin
    logic as;
    as = (cs_n_o != '1);
    if (as) begin
      cs_cyc++;
      cs_seen = cs_n_o;
      if (sclk_o == cur_lead) lead_cyc++;
      if (!mosi_oe) oe_low++;
    end else if (sclk_o != cur_cpol) idle_bad++;
    if (sclk_o != prev_sclk) tog++;
    if (as && !prev_as) runs++;
    prev_sclk = sclk_o;
    prev_as = as;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clear_mon();
    @(negedge clk);
    #2;
    cs_cyc = 0; lead_cyc = 0; tog = 0; runs = 0; idle_bad = 0; oe_low = 0;
    prev_sclk = sclk_o; prev_as = (cs_n_o != '1); cs_seen = '1;
  endtask

  task automatic wait_done();
    logic [31:0] st;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd3, st);
      if (st == 0) return;
    end
    chk(0, "R3 transfer completion", st, 0);
  endtask

  function automatic logic [31:0] model(logic [31:0] d, int w, int r, bit lsb, bit hd);
    for (int i = 0; i < w + r; i++) begin
      logic ob, ib;
      ob = lsb ? d[0] : d[31];
      if (hd) ib = (i < w) ? ob : 1'b1;
      else    ib = ~ob;
      d = lsb ? {ib, d[31:1]} : {d[30:0], ib};
    end
    return d;
  endfunction

  function automatic logic [31:0] cfg_word(bit cpol, bit cpha, bit lsb, bit hd, int wd, int rd);
    return {8'(rd - 2), 8'(wd - 2), 10'b0, hd, lsb, cpha, cpol, 2'b00};
  endfunction

  task automatic run_one(bit cpol, bit cpha, bit lsb, bit hd, int wd, int rdv, int w, int r, logic [31:0] d);
    logic [31:0] got, exp;
    cur_cpol = cpol; cur_lead = cpol ^ cpha;
    wr(2'd0, cfg_word(cpol, cpha, lsb, hd, wd, rdv));
    wr(2'd2, d);
    clear_mon();
    wr(2'd1, {8'(r), 8'(w), 16'h0005});
    wait_done();
    exp = model(d, w, r, lsb, hd);
    rd(2'd2, got);
    if (hd) chk(got == exp, "R7/R5 half-duplex data", got, exp);
    else    chk(got == exp, "R6/R5 four-wire data", got, exp);
    chk(cs_cyc == w*wd + r*rdv, "R3 cs asserted clocks", cs_cyc, w*wd + r*rdv);
    chk(lead_cyc == w*((wd+1)/2) + r*((rdv+1)/2), "R4 setup-level clocks", lead_cyc,
        w*((wd+1)/2) + r*((rdv+1)/2));
    chk(tog == 2*(w + r), "R4 sclk transitions", tog, 2*(w + r));
    chk(idle_bad == 0, "R4 idle sclk level", idle_bad, 0);
    chk(oe_low == (hd ? r*rdv : 0), "R7 mosi_oe release", oe_low, hd ? r*rdv : 0);
    if (w + r > 0) chk(cs_seen == 4'hA, "R2 cs mask", cs_seen, 4'hA);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int wds[3] = '{2, 3, 4};
    int rds[3] = '{2, 5, 3};
    int ws[4]  = '{8, 3, 0, 13};
    int rs[4]  = '{0, 5, 7, 19};
    logic [31:0] v, exp;
    int idx;
    cur_cpol = 0; cur_lead = 0;
    cs_cyc = 0; lead_cyc = 0; tog = 0; runs = 0; idle_bad = 0; oe_low = 0;
    prev_sclk = 0; prev_as = 0; cs_seen = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk(cs_n_o == 4'hF, "R1 reset cs_n", cs_n_o, 4'hF);
    chk(sclk_o == 1'b0, "R1 reset sclk", sclk_o, 0);
    rd(2'd0, v); chk(v == 0, "R1 reset config", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 reset descriptor", v, 0);
    rd(2'd3, v); chk(v == 0, "R1 reset status", v, 0);

    wr(2'd0, 32'h0000_0001);
    chk(pads_en == 1'b0, "R11 offline pads_en", pads_en, 0);
    chk(mosi_oe == 1'b0, "R11 offline mosi_oe", mosi_oe, 0);
    wr(2'd0, 32'h0302_0014);
    rd(2'd0, v); chk(v == 32'h0302_0014, "R2 config readback", v, 32'h0302_0014);
    chk(pads_en == 1'b1, "R11 online pads_en", pads_en, 1);

    idx = 0;
    for (int m = 0; m < 16; m++)
      for (int dv = 0; dv < 3; dv++)
        for (int ln = 0; ln < 4; ln++) begin
          idx++;
          run_one(m[0], m[1], m[2], m[3], wds[dv], rds[dv], ws[ln], rs[ln],
                  32'hA5C3_0F96 ^ (32'(idx) * 32'h9E37_79B9));
        end

    cur_cpol = 0; cur_lead = 0;
    wr(2'd0, cfg_word(0, 0, 0, 0, 3, 4));
    wr(2'd2, 32'h1234_5678);
    clear_mon();
    wr(2'd1, {8'd3, 8'd5, 16'h0005});
    wr(2'd2, 32'hFFFF_0000);
    wr(2'd1, {8'd6, 8'd2, 16'h0003});
    rd(2'd3, v); chk(v == 3, "R8 busy with pending descriptor", v, 3);
    rd(2'd1, v); chk(v == 32'h0602_0003, "R2 descriptor readback", v, 32'h0602_0003);
    wait_done();
    exp = model(model(32'h1234_5678, 5, 3, 0, 0), 2, 6, 0, 0);
    rd(2'd2, v); chk(v == exp, "R10/R8 chained data, write while busy ignored", v, exp);
    chk(runs == 1, "R8 single cs run", runs, 1);
    chk(cs_cyc == 57, "R8/R3 chained cs clocks", cs_cyc, 57);
    chk(cs_seen == 4'hC, "R8 second mask applied", cs_seen, 4'hC);

    clear_mon();
    wr(2'd1, 32'h0000_0005);
    repeat (3) @(negedge clk);
    rd(2'd3, v); chk(v == 0, "R9 zero-length consumed", v, 0);
    chk(runs == 0, "R9 no cs activity", runs, 0);
    chk(tog == 0, "R9 no sclk activity", tog, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule